// File: doc/BRIEF.md
# Sprite Attribute Block Copier

This block moves one 256-byte page of processor memory into the sprite attribute store of a video controller. A processor write to a dedicated trigger address starts a copy, and the byte written selects the source page. The block then pulls the processor's ready line low so the processor holds still, and drives the shared bus itself.

The copy starts with one idle alignment step. Then, for each byte, the block reads from the source page and writes that byte to the video controller's sprite data register address. The video controller cannot tell these writes from ordinary processor writes. The block advances only on processor clock-enable steps. A whole copy therefore takes a fixed 1 + 2×256 = 513 processor steps, whatever the ratio between the system clock and the processor clock.

Top module: `spr_dma_engine`

## Requirements
- R1: While reset is held and after it is released, `cpu_rdy` is 1, and `busy`, `bus_rd` and `bus_wr` are 0.
- R2: A write step (`cpu_ce`=1, `cpu_we`=1) to address `TRIG_ADDR` (default 16'hC0F0) starts a copy, and the low 8 bits of `cpu_wdata` select the source page. A write to any other address starts nothing.
- R3: During a copy, `cpu_rdy` stays 0 for exactly 513 consecutive clock-enable steps. `busy` equals the inverse of `cpu_rdy` at all times.
- R4: The first step with `cpu_rdy`=0 after a start performs no bus access: `bus_rd`=0 and `bus_wr`=0.
- R5: After the alignment step, read steps and write steps alternate, starting with a read. There are 256 of each. The read addresses are page×256 + i for i = 0, 1, …, 255, in ascending order.
- R6: Every write step drives `bus_addr` = `SPR_ADDR` (default 16'hC004). Its `bus_wdata` is the `bus_rdata` value sampled on the read step just before it.
- R7: A trigger write that arrives while a copy is running is ignored. The running copy keeps its page and its length.
- R8: The block changes state only on clock cycles where `cpu_ce`=1. With one enable every N clocks, `cpu_rdy` is low for exactly 513×N clocks.
- R9: `cpu_rdy` returns to 1 on the step after the final write. A trigger write on that step or any later one starts a new copy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_ce | input | 1 | Processor clock-enable step |
| cpu_addr | input | 16 | Processor write address |
| cpu_wdata | input | 8 | Processor write data |
| cpu_we | input | 1 | Processor write strobe |
| cpu_rdy | output | 1 | Processor ready; 0 halts the processor |
| busy | output | 1 | Copy in progress |
| bus_addr | output | 16 | Bus address driven by the block |
| bus_wdata | output | 8 | Bus write data |
| bus_rdata | input | 8 | Bus read data, sampled on read steps |
| bus_rd | output | 1 | Read step active |
| bus_wr | output | 1 | Write step active |

## Verification
The bench builds the block with its default parameters: a 16-bit address, 8-bit data and a 256-byte copy. These values put the full 513-step length, the last page (8'hFF) and the wrap of the byte index through 255 within reach. The bench runs the clock enable both on every clock and on every third clock. This shows that the step count does not depend on the clock ratio, and that the ignore window for a second trigger covers the whole copy up to the final write.

// File: rtl/spr_dma_pkg.sv
package spr_dma_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ALIGN = 2'd1,
    ST_READ  = 2'd2,
    ST_WRITE = 2'd3
  } dma_state_e;
endpackage

// File: rtl/spr_dma_trig_decode.sv
module spr_dma_trig_decode #(
  parameter int                ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] TRIG_ADDR = 16'hC0F0
) (
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_we,
  output logic              trig_hit
);
  always_comb begin
    trig_hit = cpu_we && (cpu_addr == TRIG_ADDR);
  end
endmodule

// File: rtl/spr_dma_seq.sv
module spr_dma_seq
  import spr_dma_pkg::*;
#(
  parameter int XFER_LEN = 256,
  localparam int IDX_W = $clog2(XFER_LEN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce,
  input  logic             trig_hit,
  output logic             accept,
  output dma_state_e       state,
  output logic [IDX_W-1:0] idx
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(XFER_LEN - 1);

  dma_state_e       state_d;
  logic [IDX_W-1:0] idx_d;

  always_comb begin
    accept  = ce && trig_hit && (state == ST_IDLE);
    state_d = state;
    idx_d   = idx;
    if (ce) begin
      case (state)
        ST_IDLE: begin
          if (trig_hit) begin
            state_d = ST_ALIGN;
            idx_d   = '0;
          end
        end
        ST_ALIGN: state_d = ST_READ;
        ST_READ:  state_d = ST_WRITE;
        ST_WRITE: begin
          idx_d = idx + 1'b1;
          if (idx == LAST_IDX) begin
            state_d = ST_IDLE;
          end else begin
            state_d = ST_READ;
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      idx   <= '0;
    end else begin
      state <= state_d;
      idx   <= idx_d;
    end
  end
endmodule

// File: rtl/spr_dma_datapath.sv
module spr_dma_datapath
  import spr_dma_pkg::*;
#(
  parameter int                ADDR_W   = 16,
  parameter int                DATA_W   = 8,
  parameter int                XFER_LEN = 256,
  parameter logic [ADDR_W-1:0] SPR_ADDR = 16'hC004,
  localparam int IDX_W  = $clog2(XFER_LEN),
  localparam int PAGE_W = ADDR_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce,
  input  logic              accept,
  input  dma_state_e        state,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata
);
  logic [PAGE_W-1:0] page_q, page_d;
  logic [DATA_W-1:0] byte_q, byte_d;
  logic [PAGE_W-1:0] page_src;

  generate
    if (PAGE_W <= DATA_W) begin : g_page_narrow
      assign page_src = cpu_wdata[PAGE_W-1:0];
    end else begin : g_page_wide
      assign page_src = {{(PAGE_W-DATA_W){1'b0}}, cpu_wdata};
    end
  endgenerate

  always_comb begin
    page_d = accept ? page_src : page_q;
    byte_d = (ce && state == ST_READ) ? bus_rdata : byte_q;
    if (state == ST_WRITE) begin
      bus_addr = SPR_ADDR;
    end else begin
      bus_addr = {page_q, idx};
    end
    bus_wdata = byte_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_q <= '0;
      byte_q <= '0;
    end else begin
      page_q <= page_d;
      byte_q <= byte_d;
    end
  end
endmodule

// File: rtl/spr_dma_engine.sv
module spr_dma_engine
  import spr_dma_pkg::*;
#(
  parameter int                ADDR_W    = 16,
  parameter int                DATA_W    = 8,
  parameter int                XFER_LEN  = 256,
  parameter logic [ADDR_W-1:0] TRIG_ADDR = 16'hC0F0,
  parameter logic [ADDR_W-1:0] SPR_ADDR  = 16'hC004
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_ce,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic              cpu_we,
  output logic              cpu_rdy,
  output logic              busy,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic              bus_rd,
  output logic              bus_wr
);
  localparam int IDX_W = $clog2(XFER_LEN);

  // Reset: asserts at once, releases after two clock edges.
  logic [1:0] rst_sync;
  logic       rst_n_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync <= 2'b00;
    end else begin
      rst_sync <= {rst_sync[0], 1'b1};
    end
  end
  assign rst_n_int = rst_sync[1];

  logic             trig_hit;
  logic             accept;
  dma_state_e       state;
  logic [IDX_W-1:0] idx;

  spr_dma_trig_decode #(
    .ADDR_W   (ADDR_W),
    .TRIG_ADDR(TRIG_ADDR)
  ) u_decode (
    .cpu_addr(cpu_addr),
    .cpu_we  (cpu_we),
    .trig_hit(trig_hit)
  );

  spr_dma_seq #(
    .XFER_LEN(XFER_LEN)
  ) u_seq (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .ce      (cpu_ce),
    .trig_hit(trig_hit),
    .accept  (accept),
    .state   (state),
    .idx     (idx)
  );

  spr_dma_datapath #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .XFER_LEN(XFER_LEN),
    .SPR_ADDR(SPR_ADDR)
  ) u_data (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .ce       (cpu_ce),
    .accept   (accept),
    .state    (state),
    .idx      (idx),
    .cpu_wdata(cpu_wdata),
    .bus_rdata(bus_rdata),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata)
  );

  always_comb begin
    busy    = (state != ST_IDLE);
    cpu_rdy = !busy;
    bus_rd  = (state == ST_READ);
    bus_wr  = (state == ST_WRITE);
  end
endmodule

// File: rtl/spr_dma_checker.sv
module spr_dma_checker #(
  parameter int                ADDR_W    = 16,
  parameter int                DATA_W    = 8,
  parameter int                XFER_LEN  = 256,
  parameter logic [ADDR_W-1:0] TRIG_ADDR = 16'hC0F0,
  parameter logic [ADDR_W-1:0] SPR_ADDR  = 16'hC004
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_ce,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic              cpu_we,
  input logic              cpu_rdy,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              bus_rd,
  input logic              bus_wr
);
  localparam int TOTAL = 1 + 2 * XFER_LEN;
  localparam int CNT_W = $clog2(TOTAL + 1) + 1;

  logic [CNT_W-1:0]  step_cnt;
  logic [DATA_W-1:0] rd_shadow;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_cnt  <= '0;
      rd_shadow <= '0;
    end else begin
      if (cpu_rdy) begin
        step_cnt <= '0;
      end else if (cpu_ce) begin
        step_cnt <= step_cnt + 1'b1;
      end
      if (cpu_ce && bus_rd) begin
        rd_shadow <= bus_rdata;
      end
    end
  end

  AST_IDLE_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rdy |-> (!bus_rd && !bus_wr)); // R3
  AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd && bus_wr)); // R5
  AST_WR_FOLLOWS_RD: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ce && bus_rd) |=> bus_wr); // R5
  AST_WR_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr |-> (bus_addr == SPR_ADDR)); // R6
  AST_WR_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr |-> (bus_wdata == rd_shadow)); // R6
  AST_START_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ce && cpu_we && cpu_addr == TRIG_ADDR && cpu_rdy) |=> (!cpu_rdy && !bus_rd && !bus_wr)); // R4
  AST_HOLD_NO_CE: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_ce |=> ($stable(cpu_rdy) && $stable(bus_rd) && $stable(bus_wr) && $stable(bus_addr))); // R8
  AST_STEP_TOTAL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_rdy) |-> (step_cnt == CNT_W'(TOTAL))); // R3
endmodule

bind spr_dma_engine spr_dma_checker #(
  .ADDR_W   (ADDR_W),
  .DATA_W   (DATA_W),
  .XFER_LEN (XFER_LEN),
  .TRIG_ADDR(TRIG_ADDR),
  .SPR_ADDR (SPR_ADDR)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cpu_ce   (cpu_ce),
  .cpu_addr (cpu_addr),
  .cpu_we   (cpu_we),
  .cpu_rdy  (cpu_rdy),
  .bus_addr (bus_addr),
  .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata),
  .bus_rd   (bus_rd),
  .bus_wr   (bus_wr)
);

// File: tb/spr_dma_engine_test.sv
`timescale 1ns/1ps
module spr_dma_engine_test;
  localparam logic [15:0] TRIG = 16'hC0F0;
  localparam logic [15:0] SPR  = 16'hC004;
  localparam int          STEPS = 513;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_ce = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic        cpu_we = 1'b0;
  logic        cpu_rdy, busy, bus_rd, bus_wr;
  logic [15:0] bus_addr;
  logic [7:0]  bus_wdata, bus_rdata;

  int errors = 0;
  int checks = 0;
  int ce_div = 1;
  int ce_cnt = 0;
  int cycles = 0;

  // monitor state
  logic [7:0] exp_page = '0;
  int low_steps, low_clks, rd_cnt, wr_cnt, addr_err, data_err, first_err, busy_err;

  always #2 clk = ~clk;

  spr_dma_engine uut (
    .clk(clk), .rst_n(rst_n), .cpu_ce(cpu_ce), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_we(cpu_we), .cpu_rdy(cpu_rdy), .busy(busy),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rd(bus_rd), .bus_wr(bus_wr)
  );

  function automatic logic [7:0] mem_f(input logic [15:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'hA5;
  endfunction

  assign bus_rdata = mem_f(bus_addr);

  always @(negedge clk) begin
    if (ce_cnt >= ce_div - 1) begin
      ce_cnt <= 0;
      cpu_ce <= 1'b1;
    end else begin
      ce_cnt <= ce_cnt + 1;
      cpu_ce <= 1'b0;
    end
  end

  task automatic clear_mon();
    low_steps = 0; low_clks = 0; rd_cnt = 0; wr_cnt = 0;
    addr_err = 0; data_err = 0; first_err = 0; busy_err = 0;
  endtask

  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      if (busy !== !cpu_rdy) busy_err++;
      if (!cpu_rdy) low_clks++;
      if (cpu_ce) begin
        if (!cpu_rdy && low_steps == 0 && (bus_rd || bus_wr)) first_err++;
        if (bus_rd) begin
          if (bus_addr !== {exp_page, 8'(rd_cnt)} || rd_cnt != wr_cnt) addr_err++;
          rd_cnt++;
        end
        if (bus_wr) begin
          if (bus_addr !== SPR) addr_err++;
          if (bus_wdata !== mem_f({exp_page, 8'(wr_cnt)})) data_err++;
          wr_cnt++;
        end
        if (!cpu_rdy) low_steps++;
      end
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic cpu_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); #1;
    while (!cpu_ce) begin @(negedge clk); #1; end
    cpu_addr = a; cpu_wdata = d; cpu_we = 1'b1;
    @(negedge clk);
    cpu_we = 1'b0;
  endtask

  task automatic wait_done();
    bit seen_low = 0;
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk); #1;
      if (!cpu_rdy) seen_low = 1;
      else if (seen_low) break;
    end
  endtask

  task automatic check_xfer(input string tag);
    check("R3", {tag, " ready-low steps"}, low_steps, STEPS);
    check("R3", {tag, " busy vs ready"}, busy_err, 0);
    check("R4", {tag, " alignment step access"}, first_err, 0);
    check("R5", {tag, " reads"}, rd_cnt, 256);
    check("R5", {tag, " read address/order"}, addr_err, 0);
    check("R6", {tag, " writes"}, wr_cnt, 256);
    check("R6", {tag, " write data"}, data_err, 0);
  endtask

  task automatic t_reset();
    check("R1", "ready in reset", int'(cpu_rdy), 1);
    check("R1", "busy in reset", int'(busy), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    check("R1", "ready after reset", int'(cpu_rdy), 1);
    check("R1", "bus strobes after reset", int'(bus_rd | bus_wr | busy), 0);
  endtask

  task automatic t_basic(input logic [7:0] pg, input string tag);
    clear_mon();
    exp_page = pg;
    cpu_write(TRIG, pg);
    wait_done();
    check_xfer(tag);
  endtask

  task automatic t_wrong_addr();
    clear_mon();
    cpu_write(16'hC0F1, 8'h22);
    cpu_write(SPR, 8'h22);
    repeat (10) @(negedge clk);
    #1;
    check("R2", "non-trigger write ready-low clocks", low_clks, 0);
    check("R2", "non-trigger write busy", int'(busy), 0);
  endtask

  task automatic t_ignore_busy();
    clear_mon();
    exp_page = 8'h3C;
    cpu_write(TRIG, 8'h3C);
    repeat (40) @(negedge clk);
    cpu_write(TRIG, 8'h77);
    wait_done();
    check_xfer("R7 retrigger ignored");
  endtask

  task automatic t_back_to_back();
    clear_mon();
    exp_page = 8'h10;
    cpu_write(TRIG, 8'h10);
    wait_done();
    check_xfer("R9 first");
    clear_mon();
    exp_page = 8'h11;
    cpu_write(TRIG, 8'h11);
    wait_done();
    check_xfer("R9 immediate second");
  endtask

  task automatic t_slow_ce();
    ce_div = 3;
    repeat (6) @(negedge clk);
    clear_mon();
    exp_page = 8'h5A;
    cpu_write(TRIG, 8'h5A);
    wait_done();
    check_xfer("R8 ce/3");
    check("R8", "ready-low clocks at ce/3", low_clks, STEPS * 3);
    ce_div = 1;
    repeat (6) @(negedge clk);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles == 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=finish", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    clear_mon();
    repeat (3) @(negedge clk);
    #1;
    t_reset();
    t_basic(8'h02, "R2 page 02");
    t_basic(8'hFF, "R5 last page");
    t_basic(8'h00, "R5 page 00");
    t_wrong_addr();
    t_ignore_busy();
    t_back_to_back();
    t_slow_ce();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule